// File: doc/BRIEF.md
# Matrix Product Checksum Checker

This block decides whether an n×n product C = A×B held in its registers is correct, using weighted row checksums. It never repeats the cubic-cost multiply. A host loads the three matrices element by element through a write port, then pulses start. The checker first folds B against a weight vector into a column vector s. It then walks the rows and, for each row i, builds two sums side by side: the weighted sum of row i of C, and the dot product of row i of A with s. The two sums are compared once the row is complete. A difference means the product is wrong.

There are two weight modes. The first uses a vector of all ones and runs a single pass. The second draws a pseudo-random 0/1 vector from a 16-bit shift-register generator and runs a second pass with the bitwise complement of that vector. Every column therefore carries weight one in at least one of the two passes. The work is quadratic in n. Results are a one-cycle done strobe, a sticky error flag and the index of the first row that failed.

Top module: `matprod_check`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at (`wr_row`, `wr_col`) of the matrix chosen by `wr_sel`: 0 selects A, 1 selects B, 2 selects C, and 3 selects nothing. A and B keep the low W bits and C keeps all 2W+clog2(n) bits. Writes made while `busy` is high are ignored.
- R2: `start` is taken only while `busy` is low. A start pulse while busy is dropped: the run in progress keeps its timing, and no further run follows.
- R3: With `mode` = 0 (all-ones weights) one pass is made. Row i is flagged when the sum of C's row i differs from the sum over k of A[i][k]·(sum of B's row k).
- R4: With `mode` = 1 two passes are made, the first with weight vector r and the second with its complement. r comes from a 16-bit maximal-length generator with a nonzero seed. The generator steps once per accepted start and never reaches zero.
- R5: `err` is raised when any row mismatches in any pass. A correct C never raises it, and any single corrupted element of C raises it in either mode.
- R6: `err_row` holds the index of the first row found mismatching. When only one row of C is wrong, or in mode 0, this is the lowest wrong row.
- R7: `done` is high for exactly one cycle. The edge that samples `start` is edge 1, and `done` rises on edge 1 + P·(2n² + n), where P = 1 in mode 0 and P = 2 in mode 1.
- R8: `err` and `err_row` keep their values after `done` until the next accepted start. That start clears both on the same edge.
- R9: Accumulators are 2W + 2·clog2(n) + 1 bits wide. A correct product with every element of A and B at its maximum value is reported clean.
- R10: In mode 0, two changes in one row of C that cancel in the row sum go undetected. This is an inherent limit of the plain sum.
- R11: During and after reset, `busy`, `done`, `err` and `err_row` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Element write strobe |
| wr_sel | input | 2 | Target matrix: 0 A, 1 B, 2 C, 3 none |
| wr_row | input | clog2(N) | Row of the element written |
| wr_col | input | clog2(N) | Column of the element written |
| wr_data | input | 2W+clog2(N) | Element value (A and B use the low W bits) |
| mode | input | 1 | 0 all-ones weights, 1 random weights with a complement pass |
| start | input | 1 | Start pulse, sampled while idle |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle strobe at the end of a check |
| err | output | 1 | Sticky mismatch flag |
| err_row | output | clog2(N) | Index of the first mismatching row |

## Verification
The assertions assume that `start`, `mode` and the write port are driven synchronously with known values, and that `wr_row` and `wr_col` stay below n whenever `wr_en` is high. The bench changes inputs only on falling edges and draws indices from loops bounded by n. It holds `mode` steady for a whole run and drives `wr_sel` = 3 only as a deliberate no-op. Element values are kept within W bits for A and B. C is computed exactly at its full width, and corruptions are added modulo that width, so a corrupted element always differs from the true one.

// File: rtl/mpc_pkg.sv
// Shared types for the matrix product checker.
// Assumes nothing beyond a single clock domain.
package mpc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_BSUM = 3'd1,
        ST_ROW  = 3'd2,
        ST_CMP  = 3'd3,
        ST_DONE = 3'd4
    } ctl_state_t;

    localparam logic [1:0] SEL_A = 2'd0;
    localparam logic [1:0] SEL_B = 2'd1;
    localparam logic [1:0] SEL_C = 2'd2;

endpackage

// File: rtl/mpc_lfsr.sv
// 16-bit Fibonacci shift-register generator (taps 16,14,13,11), maximal length.
// Assumes SEED is nonzero; steps only when adv is high.
module mpc_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv,
    output logic [15:0] q
);

    logic fb;

    // Feedback bit from the tap positions.
    always_comb fb = q[15] ^ q[13] ^ q[12] ^ q[10];

    // State register: load seed on reset, shift on advance.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= SEED;
        else if (adv) q <= {q[14:0], fb};
    end

    p_lfsr_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q != 16'h0000);
    p_lfsr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(q));

endmodule

// File: rtl/mpc_mat_store.sv
// One n x n register array with a single write port and a single
// combinational read port. Assumes row/col indices are below N.
module mpc_mat_store #(
    parameter int N  = 4,
    parameter int DW = 8,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] wr_row,
    input  logic [IW-1:0] wr_col,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_row,
    input  logic [IW-1:0] rd_col,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = N * N;

    logic [DW-1:0] mem [DEPTH];

    // Element storage: clear on reset, write when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
        end else if (we) begin
            mem[int'(wr_row) * N + int'(wr_col)] <= wr_data;
        end
    end

    // Read port addressed by the sequencer indices.
    always_comb rd_data = mem[int'(rd_row) * N + int'(rd_col)];

    for (genvar e = 0; e < DEPTH; e++) begin : g_hold
        p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !we |=> $stable(mem[e]));
    end

endmodule

// File: rtl/mpc_ctrl.sv
// Sequencer: walks B row by row (n*n cycles), then each row of A and C
// (n accumulate cycles plus one compare), once or twice, then one done cycle.
// Assumes start is a synchronous pulse; mode is captured at launch.
module mpc_ctrl
    import mpc_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode,
    output ctl_state_t    st,
    output logic [IW-1:0] row,
    output logic [IW-1:0] col,
    output logic          pass,
    output logic          two_pass,
    output logic          launch
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);

    // Start is accepted only while idle.
    always_comb launch = (st == ST_IDLE) && start;

    // State, index and pass registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            row      <= '0;
            col      <= '0;
            pass     <= 1'b0;
            two_pass <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st       <= ST_BSUM;
                    row      <= '0;
                    col      <= '0;
                    pass     <= 1'b0;
                    two_pass <= mode;
                end
                ST_BSUM: begin
                    if (col == LAST) begin
                        col <= '0;
                        if (row == LAST) begin
                            row <= '0;
                            st  <= ST_ROW;
                        end else begin
                            row <= row + 1'b1;
                        end
                    end else begin
                        col <= col + 1'b1;
                    end
                end
                ST_ROW: begin
                    if (col == LAST) begin
                        col <= '0;
                        st  <= ST_CMP;
                    end else begin
                        col <= col + 1'b1;
                    end
                end
                ST_CMP: begin
                    if (row == LAST) begin
                        row <= '0;
                        if (two_pass && !pass) begin
                            pass <= 1'b1;
                            st   <= ST_BSUM;
                        end else begin
                            st   <= ST_DONE;
                        end
                    end else begin
                        row <= row + 1'b1;
                        st  <= ST_ROW;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    p_start_dropped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && st != ST_DONE && start) |=> (st != ST_IDLE));
    p_pass_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pass && st != ST_IDLE) |-> two_pass);

endmodule

// File: rtl/matprod_check.sv
// Matrix product checker. Holds A, B, C; on start folds B against a
// weight vector into s, then per row compares weighted C sums with A.s.
// Assumes non-negative elements, N >= 2, indices on the write port below N.
module matprod_check
    import mpc_pkg::*;
#(
    parameter int          N    = 4,
    parameter int          W    = 8,
    parameter logic [15:0] SEED = 16'hACE1,
    localparam int         IW   = (N > 1) ? $clog2(N) : 1,
    localparam int         WC   = 2 * W + IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [IW-1:0] wr_row,
    input  logic [IW-1:0] wr_col,
    input  logic [WC-1:0] wr_data,
    input  logic          mode,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [IW-1:0] err_row
);

    localparam int WA = 2 * W + 2 * IW + 1;

    ctl_state_t    st;
    logic [IW-1:0] row, col;
    logic          pass, two_pass, launch;
    logic [15:0]   rnd;
    logic [N-1:0]  rbits, wvec;
    logic [WC-1:0] rd [3];
    logic [WA-1:0] s_q [N];
    logic [WA-1:0] cr_q, abr_q;
    logic [WA-1:0] b_term, c_term, a_term;

    mpc_ctrl #(.N(N), .IW(IW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .st(st), .row(row), .col(col), .pass(pass),
        .two_pass(two_pass), .launch(launch)
    );

    mpc_lfsr #(.SEED(SEED)) lfsr_i (
        .clk(clk), .rst_n(rst_n), .adv(launch), .q(rnd)
    );

    for (genvar m = 0; m < 3; m++) begin : g_mat
        localparam int DW = (m == 2) ? WC : W;
        logic [DW-1:0] q;
        logic          we_m;
        // Write gate: selected matrix, and only while idle.
        always_comb we_m = wr_en && !busy && (wr_sel == 2'(m));
        mpc_mat_store #(.N(N), .DW(DW), .IW(IW)) store_i (
            .clk(clk), .rst_n(rst_n), .we(we_m),
            .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data[DW-1:0]),
            .rd_row(row), .rd_col(col), .rd_data(q)
        );
        // Widen the read value to a common width.
        always_comb rd[m] = WC'(q);
    end

    for (genvar j = 0; j < N; j++) begin : g_rbit
        // Random weight bit j, reusing generator bits when N exceeds 16.
        always_comb rbits[j] = rnd[j % 16];
    end

    // Weight vector for the current pass.
    always_comb begin
        if (!two_pass) wvec = '1;
        else if (pass) wvec = ~rbits;
        else           wvec = rbits;
    end

    // Per-cycle terms: weight selects B and C, one true multiply for A.s.
    always_comb begin
        b_term = wvec[col] ? WA'(rd[SEL_B]) : '0;
        c_term = wvec[col] ? WA'(rd[SEL_C]) : '0;
        a_term = WA'(rd[SEL_A]) * s_q[col];
    end

    // Accumulators, comparison and sticky result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) s_q[k] <= '0;
            cr_q    <= '0;
            abr_q   <= '0;
            err     <= 1'b0;
            err_row <= '0;
        end else begin
            if (launch) begin
                err     <= 1'b0;
                err_row <= '0;
            end
            case (st)
                ST_BSUM: s_q[row] <= ((col == '0) ? '0 : s_q[row]) + b_term;
                ST_ROW: begin
                    cr_q  <= ((col == '0) ? '0 : cr_q) + c_term;
                    abr_q <= ((col == '0) ? '0 : abr_q) + a_term;
                end
                ST_CMP: if ((cr_q != abr_q) && !err) begin
                    err     <= 1'b1;
                    err_row <= row;
                end
                default: ;
            endcase
        end
    end

    // Status outputs decoded from the sequencer state.
    always_comb begin
        busy = (st != ST_IDLE);
        done = (st == ST_DONE);
    end

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !launch) |=> err);
    p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !err);
    p_err_row_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !launch) |=> $stable(err_row));
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !done);

endmodule

// File: tb/matprod_check_tb_top.sv
// Self-checking bench: vector table of corruption cases, then directed tests.
module matprod_check_tb_top;

    localparam int N    = 4;
    localparam int W    = 8;
    localparam int IW   = 2;
    localparam int WC   = 2 * W + IW;
    localparam int MASK = (1 << WC) - 1;
    localparam int LAT1 = 1 + 1 * (2 * N * N + N);
    localparam int LAT2 = 1 + 2 * (2 * N * N + N);

    typedef struct packed {
        int rnd; int seed; int ncor;
        int r1; int c1; int d1;
        int r2; int c2; int d2;
        int exp_err; int exp_row;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{0, 1, 0, 0, 0, 0,  0, 0, 0,  0, 0},
        '{0, 2, 1, 2, 1, 1,  0, 0, 0,  1, 2},
        '{0, 3, 1, 0, 3, 7,  0, 0, 0,  1, 0},
        '{0, 4, 1, 3, 0, -2, 0, 0, 0,  1, 3},
        '{0, 5, 2, 3, 2, 4,  1, 0, 9,  1, 1},
        '{0, 6, 2, 2, 0, 3,  2, 3, -3, 0, 0},
        '{1, 7, 0, 0, 0, 0,  0, 0, 0,  0, 0},
        '{1, 8, 1, 1, 2, 1,  0, 0, 0,  1, 1},
        '{1, 9, 1, 0, 0, 100,0, 0, 0,  1, 0},
        '{1, 10,1, 3, 3, -1, 0, 0, 0,  1, 3},
        '{1, 11,0, 0, 0, 0,  0, 0, 0,  0, 0},
        '{1, 12,1, 2, 1, 33, 0, 0, 0,  1, 2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [IW-1:0] wr_row = '0;
    logic [IW-1:0] wr_col = '0;
    logic [WC-1:0] wr_data = '0;
    logic          mode = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, err;
    logic [IW-1:0] err_row;

    int n_chk = 0;
    int n_fail = 0;
    int ma [N][N];
    int mb [N][N];
    int mc [N][N];

    always #4 clk = ~clk;

    matprod_check #(.N(N), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
        .mode(mode), .start(start), .busy(busy), .done(done),
        .err(err), .err_row(err_row)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic build(input int seed, input int maxed);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                ma[i][j] = maxed ? 255 : ((seed * 13 + i * 7 + j * 11) % 200) + 1;
                mb[i][j] = maxed ? 255 : ((seed * 17 + i * 3 + j * 5) % 240) + 1;
            end
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                mc[i][j] = 0;
                for (int k = 0; k < N; k++) mc[i][j] += ma[i][k] * mb[k][j];
            end
    endtask

    task automatic corrupt(input int r, input int c, input int d);
        mc[r][c] = (mc[r][c] + d) & MASK;
    endtask

    task automatic load_all();
        for (int m = 0; m < 3; m++)
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++) begin
                    @(negedge clk);
                    wr_en   = 1'b1;
                    wr_sel  = 2'(m);
                    wr_row  = IW'(i);
                    wr_col  = IW'(j);
                    wr_data = WC'((m == 0) ? ma[i][j] : (m == 1) ? mb[i][j] : mc[i][j]);
                end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // poke_kind: 0 none, 1 extra start pulse, 2 write to C[3][3] while busy.
    task automatic run_check(input bit rnd, input int poke_at, input int poke_kind,
                             output int lat);
        @(negedge clk);
        mode  = rnd;
        start = 1'b1;
        lat   = 0;
        while (lat < 400) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = (poke_kind == 1) && (lat == poke_at);
            if ((poke_kind == 2) && (lat == poke_at)) begin
                wr_en = 1'b1; wr_sel = 2'd2; wr_row = 2'd3; wr_col = 2'd3;
                wr_data = WC'(12345);
            end else begin
                wr_en = 1'b0;
            end
            if (done) break;
        end
        start = 1'b0;
        wr_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int lat;
        // R11: outputs during and after reset
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && err_row == 0, "R11 in reset", int'({busy, done, err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R11 busy", busy, 0);
        check(!done, "R11 done", done, 0);
        check(!err && err_row == 0, "R11 err", int'(err), 0);

        // Vector table: R3 R4 R5 R6 R7 R10
        for (int v = 0; v < NV; v++) begin
            build(VECS[v].seed, 0);
            if (VECS[v].ncor >= 1) corrupt(VECS[v].r1, VECS[v].c1, VECS[v].d1);
            if (VECS[v].ncor >= 2) corrupt(VECS[v].r2, VECS[v].c2, VECS[v].d2);
            load_all();
            run_check(VECS[v].rnd[0], 0, 0, lat);
            check(lat == (VECS[v].rnd ? LAT2 : LAT1), "R7 latency (R3/R4 pass count)",
                  lat, VECS[v].rnd ? LAT2 : LAT1);
            check(int'(err) == VECS[v].exp_err, "R5 err (R10 when cancelling)",
                  int'(err), VECS[v].exp_err);
            if (VECS[v].exp_err != 0)
                check(int'(err_row) == VECS[v].exp_row, "R6 err_row",
                      int'(err_row), VECS[v].exp_row);
            @(negedge clk);
            check(!done, "R7 done one cycle", done, 0);
        end

        // R9: maximal elements, both modes clean, then one corruption
        build(0, 1);
        load_all();
        run_check(1'b0, 0, 0, lat);
        check(!err, "R9 max clean ones", err, 0);
        run_check(1'b1, 0, 0, lat);
        check(!err, "R9 max clean random", err, 0);
        corrupt(0, 0, -1);
        load_all();
        run_check(1'b0, 0, 0, lat);
        check(err && err_row == 0, "R9 max corrupted", int'(err), 1);

        // R8: hold after done, clear on the accepting edge
        build(20, 0);
        corrupt(2, 2, 5);
        load_all();
        run_check(1'b0, 0, 0, lat);
        repeat (10) @(negedge clk);
        check(err, "R8 err held", err, 1);
        check(err_row == 2, "R8 err_row held", int'(err_row), 2);
        mode  = 1'b0;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(!err && busy, "R8 cleared at start", int'(err), 0);
        while (!done) @(negedge clk);
        check(err && err_row == 2, "R8 rerun still fails", int'(err), 1);

        // R1: writes during busy ignored; write with select 3 ignored
        build(21, 0);
        load_all();
        run_check(1'b0, 3, 2, lat);
        check(!err, "R1 busy write ignored (same run)", err, 0);
        run_check(1'b0, 0, 0, lat);
        check(!err, "R1 busy write ignored (rerun)", err, 0);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd3; wr_row = 2'd1; wr_col = 2'd1; wr_data = WC'(999);
        @(negedge clk);
        wr_en = 1'b0;
        run_check(1'b1, 0, 0, lat);
        check(!err, "R1 select 3 ignored", err, 0);

        // R2: start while busy dropped
        run_check(1'b0, 10, 1, lat);
        check(lat == LAT1, "R2 latency unchanged", lat, LAT1);
        begin
            int seen = 0;
            for (int t = 0; t < 60; t++) begin
                @(negedge clk);
                if (done || busy) seen++;
            end
            check(seen == 0, "R2 no second run", seen, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule